// File: doc/BRIEF.md
# Four-Way Set Miss and Victim Controller

This controller runs the miss path of one set in a four-way data cache. When a miss is offered, it reads the valid and dirty bits of the addressed set and chooses a way. A free way is always used first. If the set is full, a two-bit rotating pointer names the way to evict. The controller then asks memory for the new line and holds that request until memory acknowledges it. After the fill it issues a single tag-write pulse, which sets the line valid.

A dirty victim is not written back straight away. Its address and data go into a one-entry push buffer at the moment the miss is accepted. The write-back request is raised only after the new line has arrived. A later miss that would need the buffer while it is still occupied is held off until memory takes the buffered line. A miss that evicts a clean or invalid way does not have to wait.

Snoop lookups are compared against the addressed set of the array and against the push buffer. The result is reported one cycle later. When a snoop matches the push buffer, the write-back request is withheld for that reporting cycle. The coherency rules that decide line states are outside this block, and so are the data arrays and bus arbitration.

Top module: `set_victim_ctl`

## Requirements
- R1: After reset, fill_req, upd_en, cb_req, snp_hit and snp_pb_hit are 0, miss_ready is 1, and the replacement pointer is 0.
- R2: If any line_valid bit is 0, the way chosen for the miss is the lowest-numbered way whose valid bit is 0. Way w uses bit w of line_valid and line_dirty, and bits [w*TAG_W +: TAG_W] of the tag vectors.
- R3: If all four valid bits are 1, the chosen way equals the replacement pointer, and the pointer then advances by one, modulo 4.
- R4: Filling an invalid way leaves the replacement pointer unchanged.
- R5: In the cycle after a miss is accepted (miss_req and miss_ready both high at a clock edge), fill_req is 1 and fill_tag/fill_index carry the miss tag and index. They stay unchanged until fill_ack is seen at an edge.
- R6: fill_ack at an edge while fill_req is high produces upd_en for exactly one cycle, with upd_way set to the chosen way and upd_tag set to the miss tag.
- R7: When the victim is valid and dirty, cb_addr = {victim tag, miss index} and cb_data = the victim's line data, both captured at acceptance. cb_req stays 0 until the cycle in which upd_en is 1.
- R8: When no line is buffered, cb_req stays 0 through and after the fill.
- R9: While the push buffer is occupied, miss_ready is 0 for a miss whose victim would be dirty, and it remains 0 until cb_ack is taken. A miss whose victim is clean or invalid is still accepted.
- R10: cb_req stays 1 until cb_ack is seen at an edge while cb_req is high. In the cycle after that, cb_req is 0.
- R11: A snoop (snp_req at an edge) whose tag matches a way that has its snp_valid bit set gives snp_hit = 1 in the next cycle. A snoop that matches nothing gives snp_hit = 0.
- R12: A snoop whose {tag, index} equals the address held in the occupied push buffer gives snp_hit = 1 and snp_pb_hit = 1 in the next cycle. cb_req is 0 in that same cycle.
- R13: miss_ready is 0 while a fill is in progress and in the cycle in which upd_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_req | input | 1 | Miss request is present |
| miss_tag | input | TAG_W | Tag of the missing line |
| miss_index | input | IDX_W | Set index of the miss |
| miss_ready | output | 1 | Miss can be accepted this cycle |
| line_valid | input | NUM_WAYS | Valid bits of the addressed set |
| line_dirty | input | NUM_WAYS | Dirty bits of the addressed set |
| line_tags | input | NUM_WAYS*TAG_W | Stored tags of the addressed set |
| line_data | input | NUM_WAYS*LINE_W | Line data of the addressed set |
| fill_req | output | 1 | Line fill request to memory |
| fill_tag | output | TAG_W | Tag of the line to fetch |
| fill_index | output | IDX_W | Index of the line to fetch |
| fill_ack | input | 1 | Memory has delivered the line |
| upd_en | output | 1 | Write the tag and set the line valid |
| upd_way | output | WAY_W | Way to update |
| upd_tag | output | TAG_W | Tag to write |
| cb_req | output | 1 | Copyback request for the buffered victim |
| cb_addr | output | TAG_W+IDX_W | Victim address {tag, index} |
| cb_data | output | LINE_W | Victim line data |
| cb_ack | input | 1 | Memory has accepted the copyback |
| snp_req | input | 1 | Snoop lookup is present |
| snp_tag | input | TAG_W | Snoop tag |
| snp_index | input | IDX_W | Snoop set index |
| snp_valid | input | NUM_WAYS | Valid bits of the snooped set |
| snp_tags | input | NUM_WAYS*TAG_W | Stored tags of the snooped set |
| snp_hit | output | 1 | Snoop matched the array or the push buffer |
| snp_pb_hit | output | 1 | Snoop matched the push buffer |

## Verification
A corrupted replacement pointer shows up at the first fill into a full set: upd_way names the wrong way on the upd_en pulse, at most a few cycles after the miss is accepted. A push-buffer occupancy flag that is stuck or cleared too early has two visible effects. A dirty-victim miss may be accepted when it should stall, or stall when it should be accepted, which is seen on miss_ready in the same cycle. Alternatively, cb_req may drop without an acknowledge, which is seen one cycle later. A wrong captured address or data word is seen on cb_addr/cb_data at the upd_en cycle, and a lost snoop priority shows as cb_req high alongside snp_pb_hit.

// File: rtl/set_victim_pkg.sv
package set_victim_pkg;
  typedef enum logic [0:0] {
    MC_IDLE = 1'b0,
    MC_FILL = 1'b1
  } mc_state_e;
endpackage

// File: rtl/victim_pick.sv
// Chooses the way for a miss: the lowest free way, else the rotating pointer.
module victim_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [NUM_WAYS-1:0] dirty_i,
  input  logic [WAY_W-1:0]    rr_i,
  output logic [WAY_W-1:0]    way_o,
  output logic                any_free_o,
  output logic                need_push_o
);
  logic [WAY_W-1:0] free_way;
  logic             free_seen;

  // Scan from the top so the lowest free way wins.
  always_comb begin
    free_seen = 1'b0;
    free_way  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        free_seen = 1'b1;
        free_way  = WAY_W'(w);
      end
    end
  end

  assign any_free_o  = free_seen;
  assign way_o       = free_seen ? free_way : rr_i;
  assign need_push_o = !free_seen && dirty_i[rr_i];
endmodule

// File: rtl/push_buf.sv
// One-entry holding register for a dirty victim awaiting copyback.
module push_buf #(
  parameter int ADDR_W = 26,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [LINE_W-1:0] load_data_i,
  input  logic              release_i,
  input  logic              hold_i,
  input  logic              ack_i,
  output logic              full_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LINE_W-1:0] data_o,
  output logic              cb_req_o
);
  logic full_q;
  logic rel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      rel_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (load_i) begin
        full_q <= 1'b1;
        rel_q  <= 1'b0;
        addr_q <= load_addr_i;
        data_q <= load_data_i;
      end else begin
        if (release_i && full_q) rel_q <= 1'b1;
        if (cb_req_o && ack_i) begin
          full_q <= 1'b0;
          rel_q  <= 1'b0;
        end
      end
    end
  end

  assign full_o   = full_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign cb_req_o = full_q && rel_q && !hold_i;

  // The buffer is never overwritten while it holds a line.
  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !full_q);

  // A raised request that is not acknowledged keeps the line.
  assert_cb_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cb_req_o && !ack_i) |=> full_q && $stable(addr_q));
endmodule

// File: rtl/snoop_check.sv
// Compares a snoop against the addressed set and the push buffer.
module snoop_check #(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 20,
  parameter int IDX_W    = 6,
  localparam int ADDR_W  = TAG_W + IDX_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      snp_req_i,
  input  logic [TAG_W-1:0]          snp_tag_i,
  input  logic [IDX_W-1:0]          snp_index_i,
  input  logic [NUM_WAYS-1:0]       snp_valid_i,
  input  logic [NUM_WAYS*TAG_W-1:0] snp_tags_i,
  input  logic                      pb_full_i,
  input  logic [ADDR_W-1:0]         pb_addr_i,
  output logic                      hit_o,
  output logic                      pb_hit_o
);
  logic [NUM_WAYS-1:0] way_match;
  logic                pb_match;
  logic                hit_q;
  logic                pb_hit_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign way_match[w] = snp_valid_i[w] &&
                          (snp_tags_i[w*TAG_W +: TAG_W] == snp_tag_i);
  end

  assign pb_match = pb_full_i && (pb_addr_i == {snp_tag_i, snp_index_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q    <= 1'b0;
      pb_hit_q <= 1'b0;
    end else begin
      hit_q    <= snp_req_i && (pb_match || (|way_match));
      pb_hit_q <= snp_req_i && pb_match;
    end
  end

  assign hit_o    = hit_q;
  assign pb_hit_o = pb_hit_q;

  // A buffer match is always reported as a hit as well.
  assert_pb_implies_hit_R12: assert property (@(posedge clk) disable iff (rst)
    pb_hit_q |-> hit_q);
endmodule

// File: rtl/set_victim_ctl.sv
module set_victim_ctl
  import set_victim_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 20,
  parameter int IDX_W    = 6,
  parameter int LINE_W   = 64,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int ADDR_W  = TAG_W + IDX_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       miss_req,
  input  logic [TAG_W-1:0]           miss_tag,
  input  logic [IDX_W-1:0]           miss_index,
  output logic                       miss_ready,
  input  logic [NUM_WAYS-1:0]        line_valid,
  input  logic [NUM_WAYS-1:0]        line_dirty,
  input  logic [NUM_WAYS*TAG_W-1:0]  line_tags,
  input  logic [NUM_WAYS*LINE_W-1:0] line_data,
  output logic                       fill_req,
  output logic [TAG_W-1:0]           fill_tag,
  output logic [IDX_W-1:0]           fill_index,
  input  logic                       fill_ack,
  output logic                       upd_en,
  output logic [WAY_W-1:0]           upd_way,
  output logic [TAG_W-1:0]           upd_tag,
  output logic                       cb_req,
  output logic [ADDR_W-1:0]          cb_addr,
  output logic [LINE_W-1:0]          cb_data,
  input  logic                       cb_ack,
  input  logic                       snp_req,
  input  logic [TAG_W-1:0]           snp_tag,
  input  logic [IDX_W-1:0]           snp_index,
  input  logic [NUM_WAYS-1:0]        snp_valid,
  input  logic [NUM_WAYS*TAG_W-1:0]  snp_tags,
  output logic                       snp_hit,
  output logic                       snp_pb_hit
);
  mc_state_e        state_q;
  logic [WAY_W-1:0] rr_q;
  logic [WAY_W-1:0] way_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic             fill_q;
  logic             upd_q;
  logic [WAY_W-1:0] upd_way_q;
  logic [TAG_W-1:0] upd_tag_q;

  logic [WAY_W-1:0] pick_way;
  logic             any_free;
  logic             need_push;
  logic             pb_full;
  logic [ADDR_W-1:0] pb_addr;
  logic             accept;
  logic             fill_done;

  victim_pick #(.NUM_WAYS(NUM_WAYS)) i_pick (
    .valid_i     (line_valid),
    .dirty_i     (line_dirty),
    .rr_i        (rr_q),
    .way_o       (pick_way),
    .any_free_o  (any_free),
    .need_push_o (need_push)
  );

  assign miss_ready = (state_q == MC_IDLE) && !upd_q && !(pb_full && need_push);
  assign accept     = miss_req && miss_ready;
  assign fill_done  = (state_q == MC_FILL) && fill_ack;

  push_buf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_pbuf (
    .clk         (clk),
    .rst         (rst),
    .load_i      (accept && need_push),
    .load_addr_i ({line_tags[int'(pick_way)*TAG_W +: TAG_W], miss_index}),
    .load_data_i (line_data[int'(pick_way)*LINE_W +: LINE_W]),
    .release_i   (fill_done),
    .hold_i      (snp_pb_hit),
    .ack_i       (cb_ack),
    .full_o      (pb_full),
    .addr_o      (pb_addr),
    .data_o      (cb_data),
    .cb_req_o    (cb_req)
  );

  assign cb_addr = pb_addr;

  snoop_check #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_snoop (
    .clk         (clk),
    .rst         (rst),
    .snp_req_i   (snp_req),
    .snp_tag_i   (snp_tag),
    .snp_index_i (snp_index),
    .snp_valid_i (snp_valid),
    .snp_tags_i  (snp_tags),
    .pb_full_i   (pb_full),
    .pb_addr_i   (pb_addr),
    .hit_o       (snp_hit),
    .pb_hit_o    (snp_pb_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= MC_IDLE;
      rr_q      <= '0;
      way_q     <= '0;
      tag_q     <= '0;
      idx_q     <= '0;
      fill_q    <= 1'b0;
      upd_q     <= 1'b0;
      upd_way_q <= '0;
      upd_tag_q <= '0;
    end else begin
      upd_q <= 1'b0;
      unique case (state_q)
        MC_IDLE: begin
          if (accept) begin
            state_q <= MC_FILL;
            fill_q  <= 1'b1;
            tag_q   <= miss_tag;
            idx_q   <= miss_index;
            way_q   <= pick_way;
            if (!any_free) rr_q <= rr_q + 1'b1;
          end
        end
        MC_FILL: begin
          if (fill_ack) begin
            state_q   <= MC_IDLE;
            fill_q    <= 1'b0;
            upd_q     <= 1'b1;
            upd_way_q <= way_q;
            upd_tag_q <= tag_q;
          end
        end
        default: state_q <= MC_IDLE;
      endcase
    end
  end

  assign fill_req   = fill_q;
  assign fill_tag   = tag_q;
  assign fill_index = idx_q;
  assign upd_en     = upd_q;
  assign upd_way    = upd_way_q;
  assign upd_tag    = upd_tag_q;

  assert_pick_free_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && any_free) |-> !line_valid[pick_way]);

  assert_rr_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && any_free) |=> rr_q == $past(rr_q));

  assert_fill_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_ack) |=> fill_req && $stable(fill_tag) && $stable(fill_index));

  assert_upd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> !upd_en);

  assert_snoop_first_R12: assert property (@(posedge clk) disable iff (rst)
    snp_pb_hit |-> !cb_req);

  assert_busy_R13: assert property (@(posedge clk) disable iff (rst)
    (fill_req || upd_en) |-> !miss_ready);
endmodule

// File: tb/test_set_victim_ctl.sv
module test_set_victim_ctl;
  localparam int WAYS   = 4;
  localparam int TAG_W  = 20;
  localparam int IDX_W  = 6;
  localparam int LINE_W = 64;
  localparam int WAY_W  = 2;
  localparam int ADDR_W = TAG_W + IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic miss_req = 1'b0;
  logic [TAG_W-1:0] miss_tag = '0;
  logic [IDX_W-1:0] miss_index = '0;
  logic miss_ready;
  logic [WAYS-1:0] line_valid = '0;
  logic [WAYS-1:0] line_dirty = '0;
  logic [TAG_W-1:0]  bt [WAYS];
  logic [LINE_W-1:0] bd [WAYS];
  logic [TAG_W-1:0]  st [WAYS];
  logic [WAYS*TAG_W-1:0]  line_tags;
  logic [WAYS*LINE_W-1:0] line_data;
  logic [WAYS*TAG_W-1:0]  snp_tags;
  logic fill_req;
  logic [TAG_W-1:0] fill_tag;
  logic [IDX_W-1:0] fill_index;
  logic fill_ack = 1'b0;
  logic upd_en;
  logic [WAY_W-1:0] upd_way;
  logic [TAG_W-1:0] upd_tag;
  logic cb_req;
  logic [ADDR_W-1:0] cb_addr;
  logic [LINE_W-1:0] cb_data;
  logic cb_ack = 1'b0;
  logic snp_req = 1'b0;
  logic [TAG_W-1:0] snp_tag = '0;
  logic [IDX_W-1:0] snp_index = '0;
  logic [WAYS-1:0] snp_valid = '0;
  logic snp_hit;
  logic snp_pb_hit;

  assign line_tags = {bt[3], bt[2], bt[1], bt[0]};
  assign line_data = {bd[3], bd[2], bd[1], bd[0]};
  assign snp_tags  = {st[3], st[2], st[1], st[0]};

  always #10 clk = ~clk;

  set_victim_ctl #(.NUM_WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W))
  i_set_victim_ctl (
    .clk(clk), .rst(rst), .miss_req(miss_req), .miss_tag(miss_tag),
    .miss_index(miss_index), .miss_ready(miss_ready), .line_valid(line_valid),
    .line_dirty(line_dirty), .line_tags(line_tags), .line_data(line_data),
    .fill_req(fill_req), .fill_tag(fill_tag), .fill_index(fill_index),
    .fill_ack(fill_ack), .upd_en(upd_en), .upd_way(upd_way), .upd_tag(upd_tag),
    .cb_req(cb_req), .cb_addr(cb_addr), .cb_data(cb_data), .cb_ack(cb_ack),
    .snp_req(snp_req), .snp_tag(snp_tag), .snp_index(snp_index),
    .snp_valid(snp_valid), .snp_tags(snp_tags), .snp_hit(snp_hit),
    .snp_pb_hit(snp_pb_hit)
  );

  int n_chk = 0;
  int n_bad = 0;
  int m_rr = 0;
  bit m_pb_full = 0;
  bit last_free = 0;
  logic [ADDR_W-1:0] m_pb_addr = '0;
  logic [LINE_W-1:0] m_pb_data = '0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_way(input logic [3:0] v, input int rr);
    for (int i = 0; i < WAYS; i++) if (!v[i]) return i;
    return rr;
  endfunction

  task automatic do_miss(input logic [3:0] v, input logic [3:0] d, input bit ack_after);
    int way;
    bit allv, push;
    string wreq;
    logic [TAG_W-1:0] tg;
    logic [IDX_W-1:0] ix;
    tg = TAG_W'($urandom);
    ix = IDX_W'($urandom);
    for (int i = 0; i < WAYS; i++) begin
      bt[i] = TAG_W'($urandom);
      bd[i] = {$urandom, $urandom};
    end
    way  = exp_way(v, m_rr);
    allv = (v == 4'hF);
    push = allv && d[m_rr];
    wreq = !allv ? "R2" : (last_free ? "R4" : "R3");
    line_valid = v;
    line_dirty = d & v;
    miss_tag = tg;
    miss_index = ix;
    miss_req = 1'b1;
    #1;
    if (push && m_pb_full) begin
      chk("R9", "miss_ready stalled", 64'(miss_ready), 64'd0);
      for (int k = 0; k < 2; k++) begin
        tick();
        chk("R9", "no fill while stalled", 64'(fill_req), 64'd0);
        chk("R9", "still stalled", 64'(miss_ready), 64'd0);
      end
      chk("R10", "cb_req pending", 64'(cb_req), 64'd1);
      cb_ack = 1'b1;
      tick();
      cb_ack = 1'b0;
      m_pb_full = 0;
      chk("R10", "cb_req dropped after ack", 64'(cb_req), 64'd0);
      chk("R9", "miss_ready after ack", 64'(miss_ready), 64'd1);
    end else begin
      chk(m_pb_full ? "R9" : "R13", "miss_ready idle", 64'(miss_ready), 64'd1);
    end
    tick();
    miss_req = 1'b0;
    chk("R5", "fill_req", 64'(fill_req), 64'd1);
    chk("R5", "fill_tag", 64'(fill_tag), 64'(tg));
    chk("R5", "fill_index", 64'(fill_index), 64'(ix));
    chk("R13", "miss_ready busy", 64'(miss_ready), 64'd0);
    if (push) begin
      chk("R7", "cb_req before fill", 64'(cb_req), 64'd0);
      m_pb_full = 1;
      m_pb_addr = {bt[way], ix};
      m_pb_data = bd[way];
    end
    if (allv) m_rr = (m_rr + 1) % WAYS;
    last_free = !allv;
    repeat ($urandom % 4) begin
      tick();
      chk("R5", "fill_req held", 64'(fill_req), 64'd1);
      chk("R5", "fill_tag held", 64'(fill_tag), 64'(tg));
    end
    fill_ack = 1'b1;
    tick();
    fill_ack = 1'b0;
    chk("R6", "upd_en", 64'(upd_en), 64'd1);
    chk(wreq, "upd_way", 64'(upd_way), 64'(way));
    chk("R6", "upd_tag", 64'(upd_tag), 64'(tg));
    chk("R13", "miss_ready in update", 64'(miss_ready), 64'd0);
    if (m_pb_full) begin
      chk("R7", "cb_req after fill", 64'(cb_req), 64'd1);
      chk("R7", "cb_addr", 64'(cb_addr), 64'(m_pb_addr));
      chk("R7", "cb_data", cb_data, m_pb_data);
    end else begin
      chk("R8", "no cb_req", 64'(cb_req), 64'd0);
    end
    tick();
    chk("R6", "upd_en one cycle", 64'(upd_en), 64'd0);
    if (m_pb_full && ack_after) begin
      cb_ack = 1'b1;
      tick();
      cb_ack = 1'b0;
      m_pb_full = 0;
      chk("R10", "cb_req after ack", 64'(cb_req), 64'd0);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < WAYS; i++) begin
      bt[i] = '0; bd[i] = '0; st[i] = '0;
    end
    repeat (3) tick();
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "fill_req", 64'(fill_req), 64'd0);
    chk("R1", "upd_en", 64'(upd_en), 64'd0);
    chk("R1", "cb_req", 64'(cb_req), 64'd0);
    chk("R1", "snp_hit", 64'(snp_hit), 64'd0);
    chk("R1", "snp_pb_hit", 64'(snp_pb_hit), 64'd0);
    chk("R1", "miss_ready", 64'(miss_ready), 64'd1);
    tick();
    // R2 lowest free way
    do_miss(4'b0000, 4'b0000, 1);
    do_miss(4'b1010, 4'b0000, 1);
    do_miss(4'b0101, 4'b0000, 1);
    do_miss(4'b0111, 4'b0111, 1);
    // R3 rotation from pointer 0, R4 pointer kept across a free fill
    do_miss(4'hF, 4'h0, 1);
    do_miss(4'hF, 4'h0, 1);
    do_miss(4'b1011, 4'b1011, 1);
    do_miss(4'hF, 4'h0, 1);
    // R7 dirty victim left unacknowledged
    do_miss(4'hF, 4'hF, 0);
    // R12 snoop on the push buffer withholds the copyback
    snp_req = 1'b1;
    snp_tag = m_pb_addr[IDX_W +: TAG_W];
    snp_index = m_pb_addr[IDX_W-1:0];
    snp_valid = 4'b0000;
    tick();
    snp_req = 1'b0;
    chk("R12", "snp_hit", 64'(snp_hit), 64'd1);
    chk("R12", "snp_pb_hit", 64'(snp_pb_hit), 64'd1);
    chk("R12", "cb_req withheld", 64'(cb_req), 64'd0);
    tick();
    chk("R11", "snp_hit cleared", 64'(snp_hit), 64'd0);
    chk("R10", "cb_req back", 64'(cb_req), 64'd1);
    // R11 array hit and miss
    snp_tag = TAG_W'(20'h0ABCD);
    snp_index = 6'd5;
    st[2] = TAG_W'(20'h0ABCD);
    st[1] = TAG_W'(20'h0ABCD);
    snp_valid = 4'b0100;
    snp_req = 1'b1;
    tick();
    chk("R11", "array hit", 64'(snp_hit), 64'd1);
    chk("R11", "no pb hit", 64'(snp_pb_hit), 64'd0);
    snp_valid = 4'b1001;
    tick();
    snp_req = 1'b0;
    chk("R11", "array miss", 64'(snp_hit), 64'd0);
    snp_valid = 4'b0000;
    // R9 clean-victim miss proceeds with the buffer full, then a stalled one
    do_miss(4'hF, 4'h0, 0);
    do_miss(4'hF, 4'hF, 1);
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [3:0] v, d;
      v = ($urandom % 2) ? 4'hF : 4'($urandom);
      d = 4'($urandom);
      do_miss(v, d, bit'($urandom % 2));
    end
    if (m_pb_full) begin
      cb_ack = 1'b1;
      tick();
      cb_ack = 1'b0;
      chk("R10", "final ack", 64'(cb_req), 64'd0);
    end
    done = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end
endmodule